// File: doc/BRIEF.md
# Stereo DC-Blocking High-Pass Filter

This block strips the constant offset from a stereo stream of signed 24-bit ADC samples. It is a first-order recursive high-pass stage. The pole sits just inside the unit circle, at a = 1 - 2^-12, so the gain near DC falls by far more than 40 dB. Audio-band content passes at unity gain with no ripple, and the droop at 0.00045 of the sample rate is only a few hundredths of a dB. The multiplication by the pole is done as an arithmetic shift and a subtract, so no multiplier is needed. Each channel keeps its own feedback state at 16 fractional bits below the sample LSB. This keeps the truncation noise floor well below the 110 dB dynamic-range target.

Samples arrive with a one-cycle valid strobe. The filtered pair leaves one clock later with its own strobe. A single enable input selects filtering or bypass. In bypass, each sample passes through untouched. The feedback state is held at zero, and the previous-input register keeps following the stream, so turning the filter back on causes no step transient.

Top module: `dc_block_hpf`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and both sample outputs are 0.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. Both sample outputs hold their values through every cycle with `out_valid` low.
- R3: With `filt_enable` low on a valid cycle, each output equals the matching input sample of that cycle, bit for bit.
- R4: With `filt_enable` high on a valid cycle, each channel forms S' = (x - p)·2^16 + S - floor(S / 2^12), where S is the stored feedback (units of 2^-16 LSB) and p is the previous valid input of that channel. It then stores S' and outputs floor(S' / 2^16), saturated.
- R5: The filtered output saturates to the signed 24-bit range, from -8388608 to 8388607, instead of wrapping.
- R6: Any cycle with `filt_enable` low clears the feedback state to zero. Every valid sample, filtered or bypassed, becomes that channel's previous input p. As a result, the first filtered output after bypass equals the saturated difference between the new sample and the last bypassed one.
- R7: The left and right channels share no state. Stimulus on one channel never changes the other channel's output.
- R8: With a constant input held while enabled, the output magnitude decays toward zero over successive samples, which is the DC-removal behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample pair is valid this cycle |
| filt_enable | input | 1 | 1 = filter active, 0 = bypass |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample pair is valid this cycle |
| out_left | output | 24 | Left output sample, two's complement |
| out_right | output | 24 | Right output sample, two's complement |

## Verification
The assertions check the strobe timing and output hold on every cycle. They also check bit-exact pass-through whenever a bypassed sample is taken. Only the bench's scenarios can show that the filter arithmetic itself is right. The bench does this by comparing every output against an integer model of the recurrence across DC steps, full-scale jumps that force saturation, and a transition from bypass back to filtering. Channel independence and the decay of a held DC level are also shown through those scenarios, by driving one channel while the other stays still.

// File: rtl/dcb_pkg.sv
// Package: shared defaults and channel naming for the DC-blocking filter.
// Assumes two channels (left, right) interleaved on parallel buses.
package dcb_pkg;
    localparam int DCB_DATA_W   = 24;  // sample width
    localparam int DCB_FRAC_W   = 16;  // extra fractional bits in the feedback
    localparam int DCB_SHIFT    = 12;  // pole a = 1 - 2^-DCB_SHIFT
    localparam int DCB_GUARD_W  = 2;   // integer headroom in the feedback
    localparam int DCB_NUM_CH   = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } dcb_chan_e;
endpackage

// File: rtl/dcb_sat.sv
// Module: dcb_sat
// Clamps a signed value of IN_W bits into the signed range of OUT_W bits.
// Assumes IN_W > OUT_W. Purely combinational.
module dcb_sat #(
    parameter int IN_W  = 26,
    parameter int OUT_W = 24
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int EXT_W = IN_W - OUT_W + 1;
    localparam logic signed [IN_W-1:0] TOP_V = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] BOT_V = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

    // Select the clamped bound or the value itself.
    always_comb begin
        if (din > TOP_V)
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        else if (din < BOT_V)
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        else
            dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/dcb_channel.sv
// Module: dcb_channel
// One channel of the first-order DC-blocking recursion
//   S' = (x - p)*2^FRAC_W + S - (S >>> POLE_SHIFT),  y = sat(S' >>> FRAC_W)
// The feedback S carries FRAC_W fractional bits and GUARD_W headroom bits,
// so it never reaches its clamp for any 24-bit input sequence.
// Assumes enable is sampled with the valid strobe; bypass zeroes the
// feedback while the previous-input register keeps following the stream.
module dcb_channel #(
    parameter int DATA_W     = 24,
    parameter int FRAC_W     = 16,
    parameter int POLE_SHIFT = 12,
    parameter int GUARD_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic                     filt_en,
    input  logic signed [DATA_W-1:0] smp_in,
    output logic signed [DATA_W-1:0] smp_out
);
    localparam int ACC_W = DATA_W + FRAC_W + GUARD_W;
    localparam int SUM_W = ACC_W + 2;
    localparam int INT_W = ACC_W - FRAC_W;

    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_nxt;
    logic signed [DATA_W-1:0] prev_q;
    logic signed [SUM_W-1:0]  x_ext, p_ext, a_ext, diff_sc, leak, sum_w;
    logic signed [INT_W-1:0]  y_wide;
    logic signed [DATA_W-1:0] y_sat;

    // Sign-extend operands and form the next feedback value.
    always_comb begin
        x_ext   = {{(SUM_W-DATA_W){smp_in[DATA_W-1]}}, smp_in};
        p_ext   = {{(SUM_W-DATA_W){prev_q[DATA_W-1]}}, prev_q};
        a_ext   = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        diff_sc = (x_ext - p_ext) <<< FRAC_W;
        leak    = a_ext >>> POLE_SHIFT;
        sum_w   = diff_sc + a_ext - leak;
    end

    // Keep the feedback within its storage width.
    dcb_sat #(.IN_W(SUM_W), .OUT_W(ACC_W)) u_acc_clamp (
        .din  (sum_w),
        .dout (acc_nxt)
    );

    // Drop the fractional bits (floor) of the new feedback.
    assign y_wide = acc_nxt[ACC_W-1:FRAC_W];

    // Limit the result to the sample range.
    dcb_sat #(.IN_W(INT_W), .OUT_W(DATA_W)) u_out_clamp (
        .din  (y_wide),
        .dout (y_sat)
    );

    // State and output registers: update on valid, clear feedback in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            prev_q  <= '0;
            smp_out <= '0;
        end else begin
            if (!filt_en)
                acc_q <= '0;
            if (smp_vld) begin
                prev_q <= smp_in;
                if (filt_en) begin
                    acc_q   <= acc_nxt;
                    smp_out <= y_sat;
                end else begin
                    smp_out <= smp_in;
                end
            end
        end
    end
endmodule

// File: rtl/dc_block_hpf.sv
// Module: dc_block_hpf
// Stereo DC-blocking high-pass filter with bypass. One output pair per
// input pair, one clock of latency. Assumes in_valid is a single-cycle
// strobe per sample pair and filt_enable is meaningful on valid cycles.
module dc_block_hpf
    import dcb_pkg::*;
#(
    parameter int DATA_W     = DCB_DATA_W,
    parameter int FRAC_W     = DCB_FRAC_W,
    parameter int POLE_SHIFT = DCB_SHIFT,
    parameter int GUARD_W    = DCB_GUARD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     filt_enable,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);
    localparam int NCH = DCB_NUM_CH;

    logic signed [DATA_W-1:0] ch_in  [NCH];
    logic signed [DATA_W-1:0] ch_out [NCH];

    assign ch_in[CH_LEFT]  = in_left;
    assign ch_in[CH_RIGHT] = in_right;
    assign out_left        = ch_out[CH_LEFT];
    assign out_right       = ch_out[CH_RIGHT];

    // One independent filter instance per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dcb_channel #(
            .DATA_W     (DATA_W),
            .FRAC_W     (FRAC_W),
            .POLE_SHIFT (POLE_SHIFT),
            .GUARD_W    (GUARD_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (in_valid),
            .filt_en (filt_enable),
            .smp_in  (ch_in[c]),
            .smp_out (ch_out[c])
        );
    end

    // Output strobe follows the input strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end
endmodule

// File: rtl/dcb_checker.sv
// Module: dcb_checker
// Cycle-level properties of dc_block_hpf: strobe timing, output hold
// between strobes, and exact pass-through in bypass. Bound to the top.
module dcb_checker #(
    parameter int DATA_W = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     filt_enable,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right
);
    // R2: a taken sample yields a strobe on the next cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no input strobe, no output strobe
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: outputs hold while no sample is produced
    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    // R3: bypassed left sample appears unchanged
    p_bypass_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !filt_enable) |=> (out_left == $past(in_left)));

    // R3: bypassed right sample appears unchanged
    p_bypass_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !filt_enable) |=> (out_right == $past(in_right)));
endmodule

bind dc_block_hpf dcb_checker #(.DATA_W(DATA_W)) u_dcb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .filt_enable (filt_enable),
    .in_left     (in_left),
    .in_right    (in_right),
    .out_valid   (out_valid),
    .out_left    (out_left),
    .out_right   (out_right)
);

// File: tb/dc_block_hpf_tb.sv
// Scoreboard bench: the driver computes expected pairs from an integer
// model of the requirements and queues them; the monitor pops and compares.
module dc_block_hpf_tb;
    localparam int CLK_PERIOD = 10;
    localparam longint ACC_MAX = (64'sd1 <<< 41) - 1;
    localparam longint ACC_MIN = -(64'sd1 <<< 41);

    typedef struct {
        logic signed [23:0] l;
        logic signed [23:0] r;
        string              tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic filt_enable = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic out_valid;
    logic signed [23:0] out_left, out_right;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    exp_t sb_q[$];
    longint m_acc [2];
    longint m_prev [2];
    logic signed [23:0] last_l = '0;
    logic signed [23:0] last_r = '0;
    longint decay_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_block_hpf u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .filt_enable (filt_enable),
        .in_left     (in_left),
        .in_right    (in_right),
        .out_valid   (out_valid),
        .out_left    (out_left),
        .out_right   (out_right)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic longint sat24(input longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    // Model of R3/R4/R5/R6 for one channel.
    function automatic longint model(input int ch, input longint x, input bit en);
        longint s, y;
        if (en) begin
            s = (x - m_prev[ch]) * 65536 + m_acc[ch] - (m_acc[ch] >>> 12);
            if (s > ACC_MAX) s = ACC_MAX;
            if (s < ACC_MIN) s = ACC_MIN;
            m_acc[ch] = s;
            y = sat24(s >>> 16);
        end else begin
            m_acc[ch] = 0;
            y = x;
        end
        m_prev[ch] = x;
        return y;
    endfunction

    task automatic send(input int xl, input int xr, input bit en, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid    = 1'b1;
        filt_enable = en;
        in_left     = xl[23:0];
        in_right    = xr[23:0];
        e.l   = 24'(model(0, longint'(xl), en));
        e.r   = 24'(model(1, longint'(xr), en));
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: compare each produced pair; check hold when idle (R2).
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(out_left == e.l, {e.tag, " left"}, longint'(out_left), longint'(e.l));
                    chk(out_right == e.r, {e.tag, " right"}, longint'(out_right), longint'(e.r));
                end
                last_l = out_left;
                last_r = out_right;
            end else begin
                chk(out_left == last_l && out_right == last_r, "R2 hold",
                    longint'(out_left), longint'(last_l));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        m_acc  = '{0, 0};
        m_prev = '{0, 0};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0 && out_left == 0 && out_right == 0, "R1 during reset",
            longint'(out_left), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_left == 0 && out_right == 0, "R1 after reset",
            longint'(out_left), 0);
        mon_on = 1'b1;

        // R3: bypass passes samples unchanged, including extremes
        send(8388607, -8388608, 1'b0, "R3 bypass");
        send(-1, 12345, 1'b0, "R3 bypass");
        idle(2);
        send(1000, -777, 1'b0, "R3 bypass");

        // R6: first filtered output equals difference from last bypassed input
        send(1000, -777, 1'b1, "R6 reenable no step");
        send(1500, -700, 1'b1, "R6 reenable diff");
        idle(3);

        // R4/R7/R8: DC step on left, right held at zero
        send(0, 0, 1'b0, "R3 bypass zero");
        decay_prev = 0;
        for (int i = 0; i < 40; i++) begin
            send(200000, 0, 1'b1, "R4 R7 dc step");
        end
        idle(3);
        // R8: decay of the held DC level, checked on the model's trace
        // against the device through the scoreboard; verify monotone here.
        begin
            longint a, yv, yprev;
            a = 0; yprev = 200000;
            for (int k = 0; k < 40; k++) begin
                a = (k == 0 ? 200000 * 65536 : 0) + a - (a >>> 12);
                yv = a >>> 16;
                if (k > 0) chk(yv <= yprev && yv >= 0, "R8 decay model", yv, yprev);
                yprev = yv;
                if (k == 39) chk(yv < 200000, "R8 decayed", yv, 200000);
            end
        end

        // R5: full-scale jump saturates positive then negative
        send(-8388608, 8388607, 1'b0, "R3 bypass");
        send(8388607, -8388608, 1'b1, "R5 saturate");
        send(-8388608, 8388607, 1'b1, "R5 saturate back");
        send(8388607, -8388608, 1'b1, "R5 saturate again");
        idle(2);

        // R6: dropping enable between samples clears feedback
        send(0, 0, 1'b0, "R6 bypass clear");
        send(300000, -300000, 1'b1, "R6 fresh start");
        send(300000, -300000, 1'b1, "R6 fresh start");

        // R7: right channel varies while left held constant
        for (int i = 0; i < 12; i++) begin
            send(300000, (i % 2 == 0) ? 4000000 : -4000000, 1'b1, "R7 independence");
        end

        // R4/R2: random stream with gaps and occasional bypass
        for (int i = 0; i < 400; i++) begin
            int xl, xr;
            bit en;
            xl = int'($urandom_range(16777215, 0)) - 8388608;
            xr = int'($urandom_range(16777215, 0)) - 8388608;
            if (i % 4 == 0) xl = xl / 64;
            en = ($urandom_range(15, 0) != 0);
            send(xl, xr, en, "R4 random");
            if ($urandom_range(3, 0) == 0) idle(int'($urandom_range(3, 1)));
        end
        idle(5);

        // R2: every queued sample produced exactly once
        chk(sb_q.size() == 0, "R2 drained", longint'(sb_q.size()), 0);
        done = 1'b1;
        summary();
    end
endmodule